// File: doc/BRIEF.md
# Deferred-Fault Poison Tracker

This block keeps one poison bit for every entry of a small integer register file, so that loads may be hoisted above branches without trapping. A speculative load that would fault does not raise an exception. It marks its destination register as poisoned. Speculative operations that read a poisoned register pass the mark on to their own destination. The fault therefore travels with the data until one of two things resolves it. A speculation-check operation on a poisoned register sends control to a recovery target. A non-speculative consumer of a poisoned register raises the deferred exception.

One decoded operation is presented per cycle. Each operation carries its kind, two source indices, a destination index, a speculative flag, a fault flag, a qualifying predicate and a recovery target. The poison bits are updated on the clock edge that accepts the operation. The redirect and exception outputs are registered pulses that appear in the cycle after that edge. The data path, memory access and trap handling are outside this block.

Top module: `poison_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, every poison bit is clear and `redirect_o` and `excp_o` are low.
- R2: A speculative load (op_kind 1, op_spec 1) sets its destination poison bit to the OR of op_fault and the poison of its address source `op_src_a`. No exception or redirect is produced.
- R3: A speculative arithmetic op (op_kind 2, op_spec 1) sets its destination poison bit to the OR of the poison bits of both sources. No exception or redirect is produced.
- R4: A non-speculative load or arithmetic op whose sources are clean clears its destination poison bit. On a non-speculative load, op_fault has no effect.
- R5: A non-speculative consumer whose source is poisoned raises `excp_o` for one cycle and leaves its destination bit unchanged. Loads and arithmetic ops count as consumers when op_spec is 0, and a store (op_kind 4) always counts, whatever op_spec says. `excp_reg_o` reports `op_src_a` when that source is poisoned, and `op_src_b` otherwise.
- R6: A check op (op_kind 3) whose `op_src_a` is poisoned pulses `redirect_o` with `redirect_tgt_o` equal to `op_recov`. It changes no poison bit.
- R7: A check op on a clean register produces no redirect, no exception and no state change.
- R8: Register 0 is never poisoned. A write to it has no effect, and reading it as a source counts as clean.
- R9: When op_valid or op_pred is low, or when op_kind is 0 or any code from 5 to 7, no poison bit changes and no pulse is produced.
- R10: `redirect_o` and `excp_o` are high only in the cycle right after the edge that accepted a triggering op, and never both at once. `redirect_tgt_o` and `excp_reg_o` are zero when their pulse is low.
- R11: An op that names its own destination as a source reads the poison value held before that op's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously deasserted |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | 0 none, 1 load, 2 arithmetic, 3 check, 4 store |
| op_pred | input | 1 | Qualifying predicate; 0 cancels the op |
| op_spec | input | 1 | Operation is speculative |
| op_fault | input | 1 | The load would fault |
| op_src_a | input | AW | First source index (address base for loads) |
| op_src_b | input | AW | Second source index |
| op_dst | input | AW | Destination index |
| op_recov | input | TW | Recovery target for a check op |
| poison_o | output | NREG | Current poison bit of every register |
| redirect_o | output | 1 | Recovery redirect pulse |
| redirect_tgt_o | output | TW | Recovery target, valid with redirect_o |
| excp_o | output | 1 | Deferred exception pulse |
| excp_reg_o | output | AW | Poisoned register that caused the exception |

## Verification
Two things can fall on one register in the same cycle. An op can read a register's poison bit while the same op rewrites that bit, because its destination is also one of its sources. The bench provokes this in three ways: a speculative op that names its poisoned destination as a source, a non-speculative op that does the same, and a check op placed right after the op that poisons its register. In each case it judges the result by whether the old bit was seen. The pulse that comes out must reflect the value held before the edge, and the bit that is written must show up only from the next cycle. Back-to-back check ops are also judged, to see that each one produces its own pulse and its own target.

// File: rtl/poison_pkg.sv
package poison_pkg;

  typedef enum logic [2:0] {
    OPK_NONE  = 3'd0,
    OPK_LOAD  = 3'd1,
    OPK_ARITH = 3'd2,
    OPK_CHECK = 3'd3,
    OPK_STORE = 3'd4
  } op_kind_e;

endpackage

// File: rtl/poison_file.sv
module poison_file #(
  parameter int NREG = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic            wr_val,
  input  logic [AW-1:0]   rd_a_idx,
  input  logic [AW-1:0]   rd_b_idx,
  output logic            rd_a,
  output logic            rd_b,
  output logic [NREG-1:0] bits_o
);

  logic [NREG-1:0] bits_q;
  logic [NREG-1:0] bits_d;
  logic [NREG-1:0] sel;

  // per-entry next value; entry zero is tied clean
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_ent
      if (i == 0) begin : g_zero
        assign sel[i]    = 1'b0;
        assign bits_d[i] = 1'b0;
      end else begin : g_live
        assign sel[i]    = wr_en && (wr_idx == AW'(i));
        assign bits_d[i] = sel[i] ? wr_val : bits_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (wr_en) begin
      bits_q <= bits_d;
    end
  end

  assign rd_a   = bits_q[rd_a_idx];
  assign rd_b   = bits_q[rd_b_idx];
  assign bits_o = bits_q;

endmodule

// File: rtl/poison_decode.sv
module poison_decode #(
  parameter int AW = 5,
  parameter int TW = 16
) (
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic          op_pred,
  input  logic          op_spec,
  input  logic          op_fault,
  input  logic [AW-1:0] op_src_a,
  input  logic [AW-1:0] op_src_b,
  input  logic [AW-1:0] op_dst,
  input  logic [TW-1:0] op_recov,
  input  logic          pois_a,
  input  logic          pois_b,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic          wr_val,
  output logic          ev_redirect,
  output logic [TW-1:0] ev_tgt,
  output logic          ev_excp,
  output logic [AW-1:0] ev_reg
);
  import poison_pkg::*;

  op_kind_e kind;
  logic     live;
  logic     dst_real;
  logic     any_src;
  logic     want_wr;
  logic     fire_excp;

  assign kind     = op_kind_e'(op_kind);
  assign live     = op_valid && op_pred;
  assign dst_real = (op_dst != '0);
  assign any_src  = pois_a || pois_b;

  always_comb begin
    want_wr     = 1'b0;
    wr_val      = 1'b0;
    ev_redirect = 1'b0;
    ev_tgt      = '0;
    fire_excp   = 1'b0;
    ev_reg      = '0;
    if (live) begin
      unique case (kind)
        OPK_LOAD: begin
          if (op_spec) begin
            want_wr = 1'b1;
            wr_val  = op_fault || pois_a;
          end else if (pois_a) begin
            fire_excp = 1'b1;
            ev_reg    = op_src_a;
          end else begin
            want_wr = 1'b1;
            wr_val  = 1'b0;
          end
        end
        OPK_ARITH: begin
          if (op_spec) begin
            want_wr = 1'b1;
            wr_val  = any_src;
          end else if (any_src) begin
            fire_excp = 1'b1;
            ev_reg    = pois_a ? op_src_a : op_src_b;
          end else begin
            want_wr = 1'b1;
            wr_val  = 1'b0;
          end
        end
        OPK_CHECK: begin
          if (pois_a) begin
            ev_redirect = 1'b1;
            ev_tgt      = op_recov;
          end
        end
        OPK_STORE: begin
          if (any_src) begin
            fire_excp = 1'b1;
            ev_reg    = pois_a ? op_src_a : op_src_b;
          end
        end
        default: begin
          want_wr = 1'b0;
        end
      endcase
    end
  end

  assign wr_en   = want_wr && dst_real;
  assign wr_idx  = op_dst;
  assign ev_excp = fire_excp;

endmodule

// File: rtl/poison_event_reg.sv
module poison_event_reg #(
  parameter int AW = 5,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_redirect,
  input  logic [TW-1:0] ev_tgt,
  input  logic          ev_excp,
  input  logic [AW-1:0] ev_reg,
  output logic          redirect_o,
  output logic [TW-1:0] redirect_tgt_o,
  output logic          excp_o,
  output logic [AW-1:0] excp_reg_o
);

  logic          redir_q, redir_d;
  logic [TW-1:0] tgt_q, tgt_d;
  logic          excp_q, excp_d;
  logic [AW-1:0] reg_q, reg_d;

  always_comb begin
    redir_d = ev_redirect;
    tgt_d   = ev_redirect ? ev_tgt : '0;
    excp_d  = ev_excp;
    reg_d   = ev_excp ? ev_reg : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= 1'b0;
      tgt_q   <= '0;
      excp_q  <= 1'b0;
      reg_q   <= '0;
    end else begin
      redir_q <= redir_d;
      tgt_q   <= tgt_d;
      excp_q  <= excp_d;
      reg_q   <= reg_d;
    end
  end

  assign redirect_o     = redir_q;
  assign redirect_tgt_o = tgt_q;
  assign excp_o         = excp_q;
  assign excp_reg_o     = reg_q;

endmodule

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int NREG = 32,
  parameter int TW   = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_kind,
  input  logic            op_pred,
  input  logic            op_spec,
  input  logic            op_fault,
  input  logic [AW-1:0]   op_src_a,
  input  logic [AW-1:0]   op_src_b,
  input  logic [AW-1:0]   op_dst,
  input  logic [TW-1:0]   op_recov,
  output logic [NREG-1:0] poison_o,
  output logic            redirect_o,
  output logic [TW-1:0]   redirect_tgt_o,
  output logic            excp_o,
  output logic [AW-1:0]   excp_reg_o
);

  logic          pois_a, pois_b;
  logic          wr_en, wr_val;
  logic [AW-1:0] wr_idx;
  logic          ev_redirect, ev_excp;
  logic [TW-1:0] ev_tgt;
  logic [AW-1:0] ev_reg;

  poison_file #(.NREG(NREG), .AW(AW)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val),
    .rd_a_idx (op_src_a),
    .rd_b_idx (op_src_b),
    .rd_a     (pois_a),
    .rd_b     (pois_b),
    .bits_o   (poison_o)
  );

  poison_decode #(.AW(AW), .TW(TW)) u_dec (
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .op_pred     (op_pred),
    .op_spec     (op_spec),
    .op_fault    (op_fault),
    .op_src_a    (op_src_a),
    .op_src_b    (op_src_b),
    .op_dst      (op_dst),
    .op_recov    (op_recov),
    .pois_a      (pois_a),
    .pois_b      (pois_b),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_val      (wr_val),
    .ev_redirect (ev_redirect),
    .ev_tgt      (ev_tgt),
    .ev_excp     (ev_excp),
    .ev_reg      (ev_reg)
  );

  poison_event_reg #(.AW(AW), .TW(TW)) u_evt (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_redirect    (ev_redirect),
    .ev_tgt         (ev_tgt),
    .ev_excp        (ev_excp),
    .ev_reg         (ev_reg),
    .redirect_o     (redirect_o),
    .redirect_tgt_o (redirect_tgt_o),
    .excp_o         (excp_o),
    .excp_reg_o     (excp_reg_o)
  );

endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
  parameter int NREG = 32,
  parameter int TW   = 16,
  localparam int AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [2:0]      op_kind,
  input logic            op_pred,
  input logic            op_spec,
  input logic            op_fault,
  input logic [AW-1:0]   op_src_a,
  input logic [AW-1:0]   op_src_b,
  input logic [AW-1:0]   op_dst,
  input logic [TW-1:0]   op_recov,
  input logic [NREG-1:0] poison_o,
  input logic            redirect_o,
  input logic [TW-1:0]   redirect_tgt_o,
  input logic            excp_o,
  input logic [AW-1:0]   excp_reg_o
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R9
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !(op_valid && op_pred) |=> $stable(poison_o) && !redirect_o && !excp_o);

  // R2
  spec_fault_poisons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && op_valid && op_pred && op_kind == 3'd1 && op_spec && op_fault && op_dst != '0
    |=> poison_o[$past(op_dst)]);

  // R6
  check_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && op_valid && op_pred && op_kind == 3'd3 |=> $stable(poison_o) && !excp_o);

  // R6
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && op_valid && op_pred && op_kind == 3'd3 && poison_o[op_src_a]
    |=> redirect_o && redirect_tgt_o == $past(op_recov));

  // R8
  zero_never_poisoned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !poison_o[0]);

  // R10
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !(redirect_o && excp_o));

  // R10
  quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !excp_o && !redirect_o |-> excp_reg_o == '0 && redirect_tgt_o == '0);

endmodule

bind poison_tracker poison_tracker_chk #(.NREG(NREG), .TW(TW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_valid       (op_valid),
  .op_kind        (op_kind),
  .op_pred        (op_pred),
  .op_spec        (op_spec),
  .op_fault       (op_fault),
  .op_src_a       (op_src_a),
  .op_src_b       (op_src_b),
  .op_dst         (op_dst),
  .op_recov       (op_recov),
  .poison_o       (poison_o),
  .redirect_o     (redirect_o),
  .redirect_tgt_o (redirect_tgt_o),
  .excp_o         (excp_o),
  .excp_reg_o     (excp_reg_o)
);

// File: tb/poison_tracker_test.sv
module poison_tracker_test;
  localparam int NREG = 32;
  localparam int TW   = 16;
  localparam int AW   = $clog2(NREG);

  logic            clk;
  logic            rst_n;
  logic            op_valid;
  logic [2:0]      op_kind;
  logic            op_pred;
  logic            op_spec;
  logic            op_fault;
  logic [AW-1:0]   op_src_a;
  logic [AW-1:0]   op_src_b;
  logic [AW-1:0]   op_dst;
  logic [TW-1:0]   op_recov;
  logic [NREG-1:0] poison_o;
  logic            redirect_o;
  logic [TW-1:0]   redirect_tgt_o;
  logic            excp_o;
  logic [AW-1:0]   excp_reg_o;

  typedef struct {
    logic [NREG-1:0] pois;
    logic            redir;
    logic [TW-1:0]   tgt;
    logic            exc;
    logic [AW-1:0]   rg;
    string           tag;
  } exp_t;

  exp_t            sb_q[$];
  logic [NREG-1:0] model;
  int              n_checks = 0;
  int              n_err    = 0;

  poison_tracker #(.NREG(NREG), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_pred(op_pred), .op_spec(op_spec), .op_fault(op_fault),
    .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
    .op_recov(op_recov), .poison_o(poison_o), .redirect_o(redirect_o),
    .redirect_tgt_o(redirect_tgt_o), .excp_o(excp_o), .excp_reg_o(excp_reg_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  // driver: presents one op and pushes the expected result for the next cycle
  task automatic drive(input bit v, input int k, input bit p, input bit s,
                       input bit f, input int a, input int b, input int d,
                       input int rt, input string tag);
    exp_t e;
    bit   pa, pb;
    @(negedge clk);
    op_valid = v; op_kind = 3'(k); op_pred = p; op_spec = s; op_fault = f;
    op_src_a = AW'(a); op_src_b = AW'(b); op_dst = AW'(d); op_recov = TW'(rt);
    pa = (a == 0) ? 1'b0 : model[a];
    pb = (b == 0) ? 1'b0 : model[b];
    e.redir = 1'b0; e.tgt = '0; e.exc = 1'b0; e.rg = '0; e.tag = tag;
    if (v && p) begin
      case (k)
        1: if (s) begin if (d != 0) model[d] = f | pa; end
           else if (pa) begin e.exc = 1'b1; e.rg = AW'(a); end
           else if (d != 0) model[d] = 1'b0;
        2: if (s) begin if (d != 0) model[d] = pa | pb; end
           else if (pa | pb) begin e.exc = 1'b1; e.rg = pa ? AW'(a) : AW'(b); end
           else if (d != 0) model[d] = 1'b0;
        3: if (pa) begin e.redir = 1'b1; e.tgt = TW'(rt); end
        4: if (pa | pb) begin e.exc = 1'b1; e.rg = pa ? AW'(a) : AW'(b); end
        default: ;
      endcase
    end
    e.pois = model;
    sb_q.push_back(e);
  endtask

  // monitor: compares after each accepting edge
  always begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (poison_o !== e.pois || redirect_o !== e.redir || redirect_tgt_o !== e.tgt ||
          excp_o !== e.exc || excp_reg_o !== e.rg) begin
        n_err++;
        $display("FAIL %s: actual pois=%h redir=%b tgt=%h exc=%b reg=%0d expected pois=%h redir=%b tgt=%h exc=%b reg=%0d",
                 e.tag, poison_o, redirect_o, redirect_tgt_o, excp_o, excp_reg_o,
                 e.pois, e.redir, e.tgt, e.exc, e.rg);
      end
    end
  end

  initial begin
    #2000000;
    n_checks++; n_err++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    op_valid = 0; op_kind = 0; op_pred = 0; op_spec = 0; op_fault = 0;
    op_src_a = 0; op_src_b = 0; op_dst = 0; op_recov = 0;
    model = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    n_checks++;
    if (poison_o !== '0 || redirect_o !== 1'b0 || excp_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1: actual pois=%h redir=%b exc=%b expected 0 0 0", poison_o, redirect_o, excp_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_checks++;
    if (poison_o !== '0 || redirect_o !== 1'b0 || excp_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1: actual pois=%h redir=%b exc=%b expected 0 0 0", poison_o, redirect_o, excp_o);
    end

    //     v  k  p  s  f  a  b  d  tgt      tag
    drive(1, 1, 1, 1, 1, 2, 0, 5, 0,      "R2 faulting spec load");
    drive(1, 1, 1, 1, 0, 5, 0, 6, 0,      "R2 spec load from poisoned base");
    drive(1, 1, 1, 1, 1, 2, 0, 0, 0,      "R8 write to r0");
    drive(1, 2, 1, 1, 0, 1, 5, 7, 0,      "R3 spec arith propagates");
    drive(1, 2, 1, 1, 0, 1, 2, 8, 0,      "R3 spec arith clean");
    drive(1, 3, 1, 0, 0, 7, 0, 0, 'h1234, "R6 check poisoned");
    drive(1, 3, 1, 0, 0, 8, 0, 0, 'h0bad, "R7 check clean");
    drive(1, 2, 1, 0, 0, 2, 7, 9, 0,      "R5 non-spec arith src b");
    drive(1, 4, 1, 1, 0, 5, 7, 0, 0,      "R5 store priority to src a");
    drive(1, 1, 0, 1, 1, 2, 0, 10, 0,     "R9 predicate false");
    drive(0, 1, 1, 1, 1, 2, 0, 11, 0,     "R9 not valid");
    drive(1, 6, 1, 1, 1, 5, 7, 12, 'h55,  "R9 unknown kind");
    drive(1, 1, 1, 0, 1, 1, 0, 5, 0,      "R4 non-spec load ignores fault");
    drive(1, 1, 1, 1, 1, 0, 0, 3, 0,      "R2 poison r3");
    drive(1, 2, 1, 1, 0, 3, 0, 3, 0,      "R11 spec self read");
    drive(1, 2, 1, 0, 0, 3, 1, 3, 0,      "R11 non-spec self read traps");
    drive(1, 3, 1, 0, 0, 3, 0, 0, 'h0042, "R11 check right after");
    drive(1, 2, 1, 0, 0, 1, 2, 3, 0,      "R4 non-spec clean clears");
    drive(1, 2, 1, 1, 0, 0, 0, 13, 0,     "R8 r0 source clean");
    drive(1, 1, 1, 0, 0, 6, 0, 14, 0,     "R5 non-spec load poisoned base");
    drive(1, 3, 1, 0, 0, 6, 0, 0, 'h0101, "R10 back-to-back check one");
    drive(1, 3, 1, 0, 0, 7, 0, 0, 'h0202, "R10 back-to-back check two");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0,      "R10 pulse falls");
    for (int i = 1; i < NREG; i++)
      drive(1, 1, 1, 1, 1, 0, 0, i, 0, "R2 sweep poison");
    for (int i = 0; i < NREG; i++)
      drive(1, 3, 1, 0, 0, i, 0, 0, i + 16, "R6 sweep check");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    wait (sb_q.size() == 0);
    @(posedge clk);
    #3;
    summary();
    $finish;
  end

endmodule